// File: doc/BRIEF.md
# Two-Cycle Ready-Latency Stream Adapter

This block joins a streaming source that reacts to back-pressure two clocks late to a consumer that uses ordinary valid/ready handshaking. The source sees a registered ready signal from the adapter. A beat may be offered only in a cycle that lies exactly two clocks after a cycle in which that ready was high. Beats that are already on their way when ready falls still have to be kept, so a small in-order buffer stores every accepted beat. The buffer presents its oldest beat to the consumer with no added latency.

Each beat carries a data word, start-of-packet and end-of-packet flags, and an empty count. The adapter moves these fields as one unit and never looks inside them. Back-pressure on the consumer side follows the usual rules. A beat leaves in any cycle where `dn_valid` and `dn_ready` are both high. While `dn_ready` is low, the offered beat stays in place and does not change. The adapter lowers `up_ready` early enough that the beats still in flight always find free entries.

Top module: `rl2_stream_adapter`

## Requirements
- R1: While `rst` is high at a clock edge, the buffer empties and the ready history clears. In the cycle after such an edge, `dn_valid` and `up_ready` are both 0.
- R2: `up_ready` is a register. It is 1 in a cycle exactly when the buffer held at most DEPTH-LAT-1 beats at the end of the previous cycle. After reset is released with an empty buffer, it is 1 in the first cycle.
- R3: A beat is stored only when `up_valid` is 1 in a cycle whose `up_ready` was 1 exactly LAT (default 2) cycles earlier. A beat with `up_valid` low, or one offered outside such a ready cycle, is dropped and never reaches the output.
- R4: A beat stored into an empty buffer appears on `dn_valid`/`dn_data` in the cycle after the one in which it was offered.
- R5: Every stored beat leaves exactly once, in arrival order, under any pattern of `dn_ready`.
- R6: `dn_sop`, `dn_eop` and `dn_empty` leave together with the data word they arrived with (empty is EMPTY_W bits wide, default 2).
- R7: A transfer on the consumer side takes place when `dn_valid` and `dn_ready` are both 1. While `dn_valid` is 1 and `dn_ready` is 0, the beat stays offered and unchanged in the next cycle. `dn_valid` is 0 once the buffer is empty.
- R8: The buffer must hold at least LAT+1 entries. With `dn_ready` held low and a source that sends in every allowed cycle, exactly DEPTH beats are accepted and none is lost.
- R9: After a stall is drained, `up_ready` returns high and traffic resumes without losing beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Source beat valid (only honoured in ready cycles) |
| up_ready | output | 1 | Registered ready toward the source, read LAT cycles ahead |
| up_data | input | DATA_W | Source data word |
| up_sop | input | 1 | Source start of packet |
| up_eop | input | 1 | Source end of packet |
| up_empty | input | EMPTY_W | Source empty count |
| dn_valid | output | 1 | Consumer beat valid |
| dn_ready | input | 1 | Consumer ready, zero latency |
| dn_data | output | DATA_W | Consumer data word |
| dn_sop | output | 1 | Consumer start of packet |
| dn_eop | output | 1 | Consumer end of packet |
| dn_empty | output | EMPTY_W | Consumer empty count |

## Verification
A beat offered in cycle t is visible on the consumer port in cycle t+1. `up_ready` reflects the buffer level at the end of cycle t in cycle t+1. A `up_ready` value seen in cycle t sets whether a beat may be sent in cycle t+2. The bench drives its inputs on the falling edge and reads outputs there as well. Its source model keeps a three-deep record of `up_ready`, so beats are sent only in the cycles the ready latency allows. A check on a result is made at the falling edge of the cycle in which that result is due: for example, one cycle after reset release for `up_ready`, and one cycle after the offer for `dn_valid`.

// File: rtl/rla_pkg.sv
package rla_pkg;

  // Highest buffer level at which the source may still be granted a ready cycle.
  function automatic int unsigned rla_max_occ_for_ready(int unsigned depth, int unsigned lat);
    return depth - lat - 1;
  endfunction

  function automatic int unsigned rla_ptr_w(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned rla_cnt_w(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/rla_ready_pipe.sv
module rla_ready_pipe
  import rla_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LAT   = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] occ_next_i,
  output logic          up_ready_o,
  output logic          ready_cycle_o
);

  localparam int unsigned MAX_OCC = rla_max_occ_for_ready(DEPTH, LAT);

  logic          rdy_q;
  logic [LAT:1]  hist_q;

  // The decision uses next-cycle occupancy so the LAT in-flight beats plus the
  // beat of the granted cycle itself always find room.
  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= (32'(occ_next_i) <= MAX_OCC);
  end

  generate
    for (genvar k = 1; k <= LAT; k++) begin : g_hist
      if (k == 1) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) hist_q[k] <= 1'b0;
          else     hist_q[k] <= rdy_q;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) hist_q[k] <= 1'b0;
          else     hist_q[k] <= hist_q[k-1];
        end
      end
    end
  endgenerate

  assign up_ready_o    = rdy_q;
  assign ready_cycle_o = hist_q[LAT];

endmodule

// File: rtl/rla_occupancy.sv
module rla_occupancy
  import rla_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] occ_next_o,
  output logic          empty_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    unique case ({wr_i, rd_i})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign occ_o      = cnt_q;
  assign occ_next_o = cnt_d;
  assign empty_o    = (cnt_q == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> (32'(cnt_q) < DEPTH));

endmodule

// File: rtl/rla_store.sv
module rla_store
  import rla_pkg::*;
#(
  parameter int unsigned W     = 68,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wr_word_i,
  output logic [W-1:0] rd_word_o
);

  localparam int unsigned PW = rla_ptr_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q;
  logic [PW-1:0] rp_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_i) mem[wp_q] <= wr_word_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_i) wp_q <= bump(wp_q);
      if (rd_i) rp_q <= bump(rp_q);
    end
  end

  // Show-ahead: the oldest entry is always on the read port.
  assign rd_word_o = mem[rp_q];

endmodule

// File: rtl/rl2_stream_adapter.sv
module rl2_stream_adapter
  import rla_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned EMPTY_W = 2,
  parameter int unsigned LAT     = 2,
  parameter int unsigned DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [DATA_W-1:0]  up_data,
  input  logic               up_sop,
  input  logic               up_eop,
  input  logic [EMPTY_W-1:0] up_empty,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [DATA_W-1:0]  dn_data,
  output logic               dn_sop,
  output logic               dn_eop,
  output logic [EMPTY_W-1:0] dn_empty
);

  localparam int unsigned BEAT_W  = DATA_W + EMPTY_W + 2;
  localparam int unsigned CW      = rla_cnt_w(DEPTH);
  localparam int unsigned MAX_OCC = rla_max_occ_for_ready(DEPTH, LAT);

  logic              ready_cycle;
  logic              wr_en;
  logic              rd_en;
  logic              buf_empty;
  logic [CW-1:0]     occ;
  logic [CW-1:0]     occ_next;
  logic [BEAT_W-1:0] in_word;
  logic [BEAT_W-1:0] out_word;

  assign in_word = {up_sop, up_eop, up_empty, up_data};
  assign wr_en   = up_valid & ready_cycle;
  assign rd_en   = dn_valid & dn_ready;

  rla_ready_pipe #(.DEPTH(DEPTH), .LAT(LAT), .CW(CW)) u_ready (
    .clk           (clk),
    .rst           (rst),
    .occ_next_i    (occ_next),
    .up_ready_o    (up_ready),
    .ready_cycle_o (ready_cycle)
  );

  rla_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_en),
    .rd_i       (rd_en),
    .occ_o      (occ),
    .occ_next_o (occ_next),
    .empty_o    (buf_empty)
  );

  rla_store #(.W(BEAT_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (wr_en),
    .rd_i      (rd_en),
    .wr_word_i (in_word),
    .rd_word_o (out_word)
  );

  assign dn_valid = ~buf_empty;
  assign {dn_sop, dn_eop, dn_empty, dn_data} = out_word;

  // R2
  ready_level_chk: assert property (@(posedge clk) disable iff (rst)
    up_ready |-> (32'(occ) <= MAX_OCC));

  // R3
  idle_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> (occ <= $past(occ)));

  // R7
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(out_word)));

endmodule

// File: tb/test_rl2_stream_adapter.sv
module test_rl2_stream_adapter;

  localparam int unsigned DATA_W  = 64;
  localparam int unsigned EMPTY_W = 2;
  localparam int unsigned LAT     = 2;
  localparam int unsigned DEPTH   = 4;
  localparam int unsigned BW      = DATA_W + EMPTY_W + 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               up_valid = 1'b0;
  logic               up_ready;
  logic [DATA_W-1:0]  up_data = '0;
  logic               up_sop = 1'b0;
  logic               up_eop = 1'b0;
  logic [EMPTY_W-1:0] up_empty = '0;
  logic               dn_valid;
  logic               dn_ready = 1'b0;
  logic [DATA_W-1:0]  dn_data;
  logic               dn_sop;
  logic               dn_eop;
  logic [EMPTY_W-1:0] dn_empty;

  always #4 clk = ~clk;

  rl2_stream_adapter #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .LAT(LAT), .DEPTH(DEPTH))
    i_rl2_stream_adapter (
      .clk(clk), .rst(rst),
      .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
      .up_sop(up_sop), .up_eop(up_eop), .up_empty(up_empty),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
      .dn_sop(dn_sop), .dn_eop(dn_eop), .dn_empty(dn_empty));

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int recv   = 0;
  int seq    = 0;
  bit r0 = 0, r1 = 0, r2 = 0;
  logic [BW-1:0] sb[$];

  function automatic logic [BW-1:0] make_beat(input int s);
    logic [31:0] v;
    v = 32'(s);
    return {(s % 5) == 0, (s % 5) == 4, v[EMPTY_W-1:0], v, ~v};
  endfunction

  function automatic logic [BW-1:0] dn_word();
    return {dn_sop, dn_eop, dn_empty, dn_data};
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle: update ready history, drive source, drive sink and score.
  task automatic tick(input bit send, input bit take, input bit force_v);
    logic [BW-1:0] b;
    logic [BW-1:0] e;
    @(negedge clk);
    r2 = r1; r1 = r0; r0 = up_ready;
    if (send && r2 && !rst) begin
      b = make_beat(seq);
      seq++;
      {up_sop, up_eop, up_empty, up_data} = b;
      up_valid = 1'b1;
      sb.push_back(b);
      sent++;
    end else begin
      up_valid = force_v;
      {up_sop, up_eop, up_empty, up_data} = {2'b11, EMPTY_W'($urandom), $urandom, $urandom};
    end
    dn_ready = take;
    if (dn_valid && take) begin
      recv++;
      if (sb.size() == 0) begin
        check(1'b0, "R5 extra beat", dn_word(), '0);
      end else begin
        e = sb.pop_front();
        check(dn_word() == e, "R5/R6 order or sideband", dn_word(), e);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    up_valid = 1'b0;
    repeat (3) tick(0, 0, 0);
    sb.delete();
    r0 = 0; r1 = 0; r2 = 0;
    check(dn_valid == 1'b0, "R1 dn_valid in reset", BW'(dn_valid), '0);
    check(up_ready == 1'b0, "R1 up_ready in reset", BW'(up_ready), '0);
    rst = 1'b0;
    tick(0, 0, 0);
    check(up_ready == 1'b1, "R2 up_ready after release", BW'(up_ready), BW'(1));
  endtask

  task automatic drain();
    repeat (40) tick(0, 1, 0);
    check(sb.size() == 0, "R5 all beats delivered", BW'(sb.size()), '0);
    check(dn_valid == 1'b0, "R7 dn_valid low when empty", BW'(dn_valid), '0);
  endtask

  task automatic test_single();
    int s0;
    repeat (3) tick(0, 0, 0);
    s0 = sent;
    tick(1, 0, 0);
    check(sent == s0 + 1, "R3 beat sent in ready cycle", BW'(sent - s0), BW'(1));
    tick(0, 0, 0);
    check(dn_valid == 1'b1, "R4 dn_valid one cycle after offer", BW'(dn_valid), BW'(1));
    check(dn_word() == sb[0], "R4 dn beat one cycle after offer", dn_word(), sb[0]);
    tick(0, 1, 0);
    tick(0, 0, 0);
    check(dn_valid == 1'b0, "R7 empty after accept", BW'(dn_valid), '0);
  endtask

  task automatic test_ignore();
    repeat (8) tick(0, 0, 0);
    check(dn_valid == 1'b0, "R3 invalid beats ignored", BW'(dn_valid), '0);
  endtask

  task automatic test_stall();
    int s0;
    logic [BW-1:0] held;
    s0 = sent;
    repeat (12) tick(1, 0, 0);
    check(sent - s0 == DEPTH, "R8 beats accepted while stalled", BW'(sent - s0), BW'(DEPTH));
    check(up_ready == 1'b0, "R2 up_ready low when full", BW'(up_ready), '0);
    held = dn_word();
    check(dn_valid && held == sb[0], "R7 head beat offered", held, sb[0]);
    repeat (4) tick(0, 0, 1);
    check(dn_word() == held, "R7 head beat stable", dn_word(), held);
    repeat (DEPTH) tick(0, 1, 0);
    repeat (3) tick(0, 0, 0);
    check(dn_valid == 1'b0, "R3 out-of-window beats dropped", BW'(dn_valid), '0);
    check(sb.size() == 0, "R8 nothing lost in stall", BW'(sb.size()), '0);
    check(up_ready == 1'b1, "R9 up_ready back after drain", BW'(up_ready), BW'(1));
    s0 = sent;
    repeat (8) tick(1, 1, 0);
    check(sent > s0, "R9 traffic resumes", BW'(sent - s0), BW'(1));
    drain();
  endtask

  task automatic test_random();
    int ps[4] = '{100, 70, 40, 90};
    int pt[4] = '{100, 30, 90, 10};
    int s0, q0;
    s0 = sent; q0 = recv;
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 600; i++)
        tick($urandom_range(0, 99) < ps[ph], $urandom_range(0, 99) < pt[ph], 0);
    end
    drain();
    check(recv - q0 == sent - s0, "R5 count in equals count out", BW'(recv - q0), BW'(sent - s0));
  endtask

  task automatic test_midreset();
    repeat (10) tick(1, 0, 0);
    check(dn_valid == 1'b1, "R8 buffer filled before reset", BW'(dn_valid), BW'(1));
    do_reset();
    repeat (4) tick(0, 1, 0);
    check(recv >= 0 && dn_valid == 1'b0, "R1 buffer emptied by reset", BW'(dn_valid), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    test_single();
    test_ignore();
    test_stall();
    test_random();
    test_midreset();
    test_single();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule